// File: doc/BRIEF.md
# Two-Level Bus Select Decoder

This block sits beside a small processor and turns every bus cycle into chip selects. On each clock it samples an address, a flag that marks the cycle as I/O or memory, read and write strobes, and a privilege flag. All of its outputs are registered, so they reflect the cycle sampled on the previous clock edge.

Decoding happens in two levels. The first level matches the upper byte of the address against a table of memory regions, or it forms one combined I/O select. In a memory cycle, three address bits just above an 8-bit offset also drive a set of eight bank enables inside the selected region. The second level expands the combined I/O select into one select per peripheral. Only the low ten address bits take part in this step, so I/O addresses alias.

Mapped I/O cycles are stretched by a fixed number of wait clocks. Memory cycles complete without waiting. Two conditions raise a one-clock flag and assert no select: a user-mode write to I/O space, which raises the trap flag, and an access that hits nothing, which raises the unmapped flag.

Top module: `bus_select_unit`

## Requirements
- R1: An I/O select asserts only for a cycle sampled with `io_space`=1, and a memory select only for a cycle sampled with `io_space`=0.
- R2: In a memory cycle, `mem_cs[i]` asserts when address bits [31:24] equal region tag i (defaults: 0x00, 0x10, 0x40, 0x80 for i=0..3). Bits [23:0] have no effect on which region is chosen.
- R3: While a memory region is selected, `bank_en` is one-hot, with bit k set where k = address bits [10:8]. At all other times `bank_en` is zero.
- R4: An I/O decode uses only address bits [9:0]. Addresses that differ only in bits [15:10] or above select the same peripheral (for example 0x8064 and 0x0064).
- R5: `io_cs[j]` asserts only inside an allowed I/O cycle, and only when address bits [9:4] equal bits [9:4] of peripheral base j (defaults: 0x010, 0x060, 0x200, 0x300 for j=0..3).
- R6: Suppose a mapped I/O access is sampled on edge k, with inputs held. Then `ready` is low after edges k through k+IO_WAIT-1 and high after edge k+IO_WAIT. Edge k+IO_WAIT+1 is the transfer edge, and it does not start a new wait.
- R7: A memory cycle leaves `ready` high.
- R8: A cycle sampled with `user_mode`=1, `io_space`=1 and `wr_stb`=1 asserts no select, leaves `ready` high, and raises `trap` for the clock after each such sampled cycle. User-mode I/O reads and user-mode memory writes decode normally.
- R9: A read or write that matches no region (memory) or no peripheral (I/O) asserts no select, leaves `ready` high, and raises `unmapped` for one clock per sampled cycle.
- R10: At most one bit of {`mem_cs`, `io_cs`} is high in any clock. All selects are low after a clock in which neither strobe was asserted.
- R11: During and right after reset, all selects, `trap` and `unmapped` are low, and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (32) | Cycle address |
| io_space | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| mem_cs | output | NUM_REGIONS (4) | One-hot memory region selects |
| bank_en | output | 8 | One-hot bank enable inside the selected region |
| io_cs | output | NUM_IO (4) | One-hot peripheral selects |
| ready | output | 1 | Low while I/O wait states run |
| trap | output | 1 | One-clock pulse on a blocked user I/O write |
| unmapped | output | 1 | One-clock pulse on an access that hits nothing |

## Verification
A faulty wait counter shows up at `ready`. It either stays low longer or shorter than IO_WAIT clocks after a mapped I/O access, or it starts a second wait on the transfer edge. Either fault is visible within IO_WAIT+2 clocks. A faulty decode register shows up one clock after the sampled cycle: the wrong select or bank bit is high, the wrong flag pulses, or two selects are high at once. Aliasing and tag faults appear the first time an address with high bits set, or an unlisted tag, is presented.

// File: rtl/bsu_pkg.sv
`timescale 1ns/1ps
package bsu_pkg;
  localparam int TAG_BITS    = 8;   // region tag width (top of address)
  localparam int IO_DEC_BITS = 10;  // decoded I/O address bits
  localparam int BANK_LSB    = 8;   // bank field sits above 8-bit offset
  localparam int BANK_BITS   = 3;
  localparam int NUM_BANKS   = 1 << BANK_BITS;
endpackage

// File: rtl/bsu_region_decode.sv
`timescale 1ns/1ps
// First level: memory region match, aggregate I/O select, privilege block.
module bsu_region_decode
  import bsu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS*TAG_BITS-1:0] REGION_TAGS = {8'h80, 8'h40, 8'h10, 8'h00}
) (
  input  logic [TAG_BITS-1:0]    tag,
  input  logic                   io_space,
  input  logic                   rd_stb,
  input  logic                   wr_stb,
  input  logic                   user_mode,
  output logic [NUM_REGIONS-1:0] mem_hit,
  output logic                   io_agg,
  output logic                   trap_req,
  output logic                   mem_miss
);
  logic active;
  logic io_block;

  assign active   = rd_stb | wr_stb;
  assign io_block = io_space & user_mode & wr_stb;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign mem_hit[i] = active & ~io_space &
                        (tag == REGION_TAGS[i*TAG_BITS +: TAG_BITS]);
  end

  always_comb begin
    io_agg   = active & io_space & ~io_block;
    trap_req = active & io_block;
    mem_miss = active & ~io_space & ~(|mem_hit);
  end
endmodule

// File: rtl/bsu_io_decode.sv
`timescale 1ns/1ps
// Second level: expand aggregate I/O select into peripheral selects.
module bsu_io_decode
  import bsu_pkg::*;
#(
  parameter int NUM_IO    = 4,
  parameter int SLOT_BITS = 4,
  parameter logic [NUM_IO*IO_DEC_BITS-1:0] IO_BASES = {10'h300, 10'h200, 10'h060, 10'h010}
) (
  input  logic [IO_DEC_BITS-SLOT_BITS-1:0] io_page,
  input  logic                             io_agg,
  output logic [NUM_IO-1:0]                io_hit,
  output logic                             io_miss
);
  localparam int PW = IO_DEC_BITS - SLOT_BITS;

  for (genvar j = 0; j < NUM_IO; j++) begin : g_periph
    assign io_hit[j] = io_agg & (io_page == IO_BASES[j*IO_DEC_BITS + SLOT_BITS +: PW]);
  end

  assign io_miss = io_agg & ~(|io_hit);
endmodule

// File: rtl/bsu_wait_ctrl.sv
`timescale 1ns/1ps
// Stretches mapped I/O cycles by IO_WAIT clocks.
module bsu_wait_ctrl #(
  parameter int IO_WAIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic io_start,
  output logic ready
);
  localparam int CW = (IO_WAIT < 1) ? 1 : $clog2(IO_WAIT + 1);

  logic [CW-1:0] cnt;
  logic          hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      hold  <= 1'b0;
      ready <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - CW'(1);
      ready <= (cnt == CW'(1));
      hold  <= (cnt == CW'(1));
    end else if (hold) begin
      hold  <= 1'b0;     // transfer edge: the held access completes here
      ready <= 1'b1;
    end else if (io_start && (IO_WAIT != 0)) begin
      cnt   <= CW'(IO_WAIT);
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_select_unit.sv
`timescale 1ns/1ps
module bus_select_unit
  import bsu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int NUM_IO      = 4,
  parameter int SLOT_BITS   = 4,
  parameter int IO_WAIT     = 3,
  parameter logic [NUM_REGIONS*TAG_BITS-1:0] REGION_TAGS = {8'h80, 8'h40, 8'h10, 8'h00},
  parameter logic [NUM_IO*IO_DEC_BITS-1:0]   IO_BASES    = {10'h300, 10'h200, 10'h060, 10'h010}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   io_space,
  input  logic                   rd_stb,
  input  logic                   wr_stb,
  input  logic                   user_mode,
  output logic [NUM_REGIONS-1:0] mem_cs,
  output logic [NUM_BANKS-1:0]   bank_en,
  output logic [NUM_IO-1:0]      io_cs,
  output logic                   ready,
  output logic                   trap,
  output logic                   unmapped
);
  logic [NUM_REGIONS-1:0] mem_hit;
  logic [NUM_IO-1:0]      io_hit;
  logic [NUM_BANKS-1:0]   bank_n;
  logic                   io_agg, trap_req, mem_miss, io_miss;
  logic                   unused_addr;

  assign unused_addr = ^{bus_addr[ADDR_W-TAG_BITS-1:BANK_LSB+BANK_BITS],
                         bus_addr[SLOT_BITS-1:0]};

  bsu_region_decode #(
    .NUM_REGIONS(NUM_REGIONS),
    .REGION_TAGS(REGION_TAGS)
  ) u_level1 (
    .tag      (bus_addr[ADDR_W-1 -: TAG_BITS]),
    .io_space (io_space),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .user_mode(user_mode),
    .mem_hit  (mem_hit),
    .io_agg   (io_agg),
    .trap_req (trap_req),
    .mem_miss (mem_miss)
  );

  bsu_io_decode #(
    .NUM_IO   (NUM_IO),
    .SLOT_BITS(SLOT_BITS),
    .IO_BASES (IO_BASES)
  ) u_level2 (
    .io_page(bus_addr[IO_DEC_BITS-1:SLOT_BITS]),
    .io_agg (io_agg),
    .io_hit (io_hit),
    .io_miss(io_miss)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_n[b] = (|mem_hit) &
                       (bus_addr[BANK_LSB +: BANK_BITS] == BANK_BITS'(b));
  end

  bsu_wait_ctrl #(
    .IO_WAIT(IO_WAIT)
  ) u_wait (
    .clk     (clk),
    .rst     (rst),
    .io_start(|io_hit),
    .ready   (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs   <= '0;
      bank_en  <= '0;
      io_cs    <= '0;
      trap     <= 1'b0;
      unmapped <= 1'b0;
    end else begin
      mem_cs   <= mem_hit;
      bank_en  <= bank_n;
      io_cs    <= io_hit;
      trap     <= trap_req;
      unmapped <= mem_miss | io_miss;
    end
  end
endmodule

// File: rtl/bsu_checker.sv
`timescale 1ns/1ps
module bsu_checker #(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_IO      = 4,
  parameter int NUM_BANKS   = 8,
  parameter int IO_WAIT     = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   io_space,
  input logic                   rd_stb,
  input logic                   wr_stb,
  input logic                   user_mode,
  input logic [NUM_REGIONS-1:0] mem_cs,
  input logic [NUM_BANKS-1:0]   bank_en,
  input logic [NUM_IO-1:0]      io_cs,
  input logic                   ready,
  input logic                   trap,
  input logic                   unmapped
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)         low_run <= '0;
    else if (!ready) low_run <= low_run + 32'd1;
    else             low_run <= '0;
  end

  p_space_io_r1: assert property (@(posedge clk) disable iff (rst)
    (|io_cs) |-> $past(io_space));
  p_space_mem_r1: assert property (@(posedge clk) disable iff (rst)
    (|mem_cs) |-> !$past(io_space));
  p_bank_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_en) && ((|bank_en) == (|mem_cs)));
  p_wait_bound_r6: assert property (@(posedge clk) disable iff (rst)
    low_run <= 32'(IO_WAIT));
  p_wait_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(io_space && (rd_stb || wr_stb) && !(user_mode && wr_stb)));
  p_trap_r8: assert property (@(posedge clk) disable iff (rst)
    trap |-> ((io_cs == '0) && $past(user_mode && wr_stb && io_space)));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> ({mem_cs, io_cs} == '0));
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_cs, io_cs}));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stb || wr_stb) |-> ({mem_cs, io_cs} == '0));
endmodule

bind bus_select_unit bsu_checker #(
  .NUM_REGIONS(NUM_REGIONS),
  .NUM_IO     (NUM_IO),
  .NUM_BANKS  (bsu_pkg::NUM_BANKS),
  .IO_WAIT    (IO_WAIT)
) u_bsu_checker (
  .clk      (clk),
  .rst      (rst),
  .io_space (io_space),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .user_mode(user_mode),
  .mem_cs   (mem_cs),
  .bank_en  (bank_en),
  .io_cs    (io_cs),
  .ready    (ready),
  .trap     (trap),
  .unmapped (unmapped)
);

// File: tb/bus_select_unit_bench.sv
`timescale 1ns/1ps
module bus_select_unit_bench;
  localparam int W = 3;  // IO_WAIT default

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        io_space = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, user_mode = 1'b0;
  logic [3:0]  mem_cs, io_cs;
  logic [7:0]  bank_en;
  logic        ready, trap, unmapped;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_select_unit u_bus_select_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .io_space(io_space),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .user_mode(user_mode),
    .mem_cs(mem_cs), .bank_en(bank_en), .io_cs(io_cs),
    .ready(ready), .trap(trap), .unmapped(unmapped)
  );

  function automatic logic [7:0] region_tag(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h10;
      2: return 8'h40;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [9:0] io_base(input int j);
    case (j)
      0: return 10'h010;
      1: return 10'h060;
      2: return 10'h200;
      default: return 10'h300;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] a, input logic io, input logic r,
                       input logic w, input logic u);
    bus_addr = a; io_space = io; rd_stb = r; wr_stb = w; user_mode = u;
  endtask

  task automatic idle();
    drive(32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R11 mem_cs", {28'h0, mem_cs}, 32'h0);
    chk("R11 io_cs", {28'h0, io_cs}, 32'h0);
    chk("R11 ready", {31'h0, ready}, 32'h1);
    chk("R11 trap", {31'h0, trap}, 32'h0);
    chk("R11 unmapped", {31'h0, unmapped}, 32'h0);
  endtask

  task automatic t_memory();
    for (int i = 0; i < 4; i++) begin
      for (int b = 0; b < 8; b += 3) begin
        logic [31:0] a;
        a = {region_tag(i), 13'h1A5, 3'(b), 8'h3C};
        drive(a, 1'b0, (b % 2) == 0, (b % 2) == 1, 1'b0);
        step();
        chk("R2 mem_cs", {28'h0, mem_cs}, 32'h1 << i);
        chk("R3 bank_en", {24'h0, bank_en}, 32'h1 << b);
        chk("R1 io_cs in mem cycle", {28'h0, io_cs}, 32'h0);
        chk("R7 ready", {31'h0, ready}, 32'h1);
      end
    end
    drive({8'h40, 24'hFFFFFF}, 1'b0, 1'b1, 1'b0, 1'b0);
    step();
    chk("R2 low bits ignored", {28'h0, mem_cs}, 32'h4);
    idle();
    step();
    chk("R10 idle mem_cs", {28'h0, mem_cs}, 32'h0);
    chk("R3 bank idle", {24'h0, bank_en}, 32'h0);
  endtask

  task automatic t_mem_unmapped();
    drive(32'h5500_0100, 1'b0, 1'b1, 1'b0, 1'b0);
    step();
    chk("R9 unmapped mem", {31'h0, unmapped}, 32'h1);
    chk("R9 no mem_cs", {28'h0, mem_cs}, 32'h0);
    chk("R9 ready", {31'h0, ready}, 32'h1);
    idle();
    step();
    chk("R9 pulse ends", {31'h0, unmapped}, 32'h0);
  endtask

  task automatic io_access(input logic [31:0] a, input int j, input logic w, input string tag);
    drive(a, 1'b1, !w, w, 1'b0);
    for (int k = 0; k < W; k++) begin
      step();
      chk({"R6 wait low ", tag}, {31'h0, ready}, 32'h0);
      chk({"R5 io_cs ", tag}, {28'h0, io_cs}, 32'h1 << j);
      chk({"R1 no mem_cs ", tag}, {28'h0, mem_cs}, 32'h0);
    end
    step();
    chk({"R6 ready back ", tag}, {31'h0, ready}, 32'h1);
    step();
    chk({"R6 no restart ", tag}, {31'h0, ready}, 32'h1);
    idle();
    step();
    chk({"R10 io idle ", tag}, {28'h0, io_cs}, 32'h0);
  endtask

  task automatic t_io();
    for (int j = 0; j < 4; j++)
      io_access({22'h0, io_base(j)} + 32'h5, j, j[0], "periph");
    io_access(32'h0000_8064, 1, 1'b0, "R4 alias 8064");
    io_access(32'h0000_FC64, 1, 1'b1, "R4 alias FC64");
    io_access(32'h1000_0064, 1, 1'b0, "R1 tag bits in io");
  endtask

  task automatic t_io_unmapped();
    drive(32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    chk("R9 unmapped io", {31'h0, unmapped}, 32'h1);
    chk("R9 io no cs", {28'h0, io_cs}, 32'h0);
    chk("R9 io no wait", {31'h0, ready}, 32'h1);
    idle();
    step();
  endtask

  task automatic t_user();
    drive(32'h0000_0064, 1'b1, 1'b0, 1'b1, 1'b1);
    step();
    chk("R8 trap", {31'h0, trap}, 32'h1);
    chk("R8 blocked io_cs", {28'h0, io_cs}, 32'h0);
    chk("R8 ready high", {31'h0, ready}, 32'h1);
    chk("R8 not unmapped", {31'h0, unmapped}, 32'h0);
    idle();
    step();
    chk("R8 trap one clock", {31'h0, trap}, 32'h0);
    drive(32'h8010_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    step();
    chk("R8 user mem write", {28'h0, mem_cs}, 32'h8);
    chk("R8 no trap mem", {31'h0, trap}, 32'h0);
    idle();
    step();
    drive(32'h0000_0304, 1'b1, 1'b1, 1'b0, 1'b1);
    step();
    chk("R8 user io read", {28'h0, io_cs}, 32'h8);
    chk("R8 user read no trap", {31'h0, trap}, 32'h0);
    for (int k = 0; k < W + 1; k++) step();
    idle();
    step();
  endtask

  task automatic t_idle();
    drive(32'h0000_0064, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R10 no strobe io", {28'h0, io_cs}, 32'h0);
    drive(32'h1000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R10 no strobe mem", {28'h0, mem_cs}, 32'h0);
    chk("R10 no strobe ready", {31'h0, ready}, 32'h1);
  endtask

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_memory();
    t_mem_unmapped();
    t_io();
    t_io_unmapped();
    t_user();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule